// File: doc/BRIEF.md
# Control-Flow Instruction Classifier

This block labels a recorded control-flow change by looking at the instruction found at its source address. A feeder supplies the first opcode byte, the byte after a 0x0F escape, the ModRM byte and the relative-call immediate. It also supplies flags that say whether the source and target are in kernel space, whether either address was zero, whether the instruction bytes could be fetched, and whether the change was a transaction abort. The block returns an 18-bit class mask. The mask has at most one branch-class bit set. When the mask is not empty, it also carries exactly one bit that gives the privilege level of the target.

Besides plain opcode matching, the block recognises a user-to-kernel transition whose source instruction is not a ring-entry instruction, and reports it as an interrupt, trap or fault. A near relative call with a zero immediate is reported as its own zero-length-call class.

The block is a two-stage pipeline with a valid/ready handshake on both sides. It accepts one request per cycle, and a result appears two cycles after it is accepted.

Top module: `branch_classifier`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: If `in_from_zero` or `in_to_zero` is set, the class is 0, whatever the other inputs are.
- R3: If neither address flag is set and `in_abort` is 1, the class is bit 12 OR the target-privilege bit, regardless of opcode. The target-privilege bit is bit 1 when `in_dst_kernel` is 1 and bit 0 otherwise.
- R4: If there is no zero address and no abort, and `in_bytes_ok` is 0, the class is 0.
- R5: Single-byte opcodes map as follows.
  - 0x70–0x7F and 0xE0–0xE3 give conditional (bit 8).
  - 0xC2, 0xC3, 0xCA and 0xCB give return (bit 3).
  - 0xCF gives interrupt-return (bit 7).
  - 0xCC–0xCE give software interrupt (bit 6).
  - 0x9A gives call (bit 2).
  - 0xE9–0xEB give jump (bit 9).
- R6: After the 0x0F escape, the second byte maps as follows: 0x05 and 0x34 give syscall (bit 4), 0x07 and 0x35 give syscall-return (bit 5), and 0x80–0x8F give conditional (bit 8).
- R7: Opcode 0xE8 gives call (bit 2) when `in_imm` is nonzero, and zero-length call (bit 15) when `in_imm` is zero.
- R8: Opcode 0xFF with ModRM bits 5:3 equal to 2 or 3 gives indirect call (bit 11). Values 4 or 5 give indirect jump (bit 17). Any other value gives no class.
- R9: A user source with a kernel target is reported as irq/trap/fault (bit 10) unless the decoded class is syscall or software interrupt. This holds even for an unrecognised opcode.
- R10: Whenever the class is nonzero, exactly one of bit 0 (user target) and bit 1 (kernel target) is set, chosen by `in_dst_kernel`. At most one bit of bits 17:2 is set.
- R11: A request accepted on an edge produces its result two edges later when the output is not stalled. While `out_valid` is high and `out_ready` is low, `out_class` holds. Results leave in request order.
- R12: Any other opcode gives class 0 when there is no user-to-kernel transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_opcode0 | input | 8 | First opcode byte |
| in_opcode1 | input | 8 | Byte following a 0x0F escape |
| in_modrm | input | 8 | ModRM byte |
| in_imm | input | IMM_W | Immediate of a near relative call |
| in_bytes_ok | input | 1 | Instruction bytes were fetched |
| in_from_zero | input | 1 | Source address was zero |
| in_to_zero | input | 1 | Target address was zero |
| in_src_kernel | input | 1 | Source is in kernel space |
| in_dst_kernel | input | 1 | Target is in kernel space |
| in_abort | input | 1 | Change was a transaction abort |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 18 | Class mask |

## Verification
A wrong decode entry shows up as a wrong class mask on the very result that carries that opcode. This appears two cycles after acceptance. A privilege merge that is applied in the wrong order shows up in the same way, but only for requests that combine an abort, a zero address or a privilege transition. A broken ready chain or stage enable shows up as lost, duplicated or reordered results, or as `out_class` changing during a stall. This becomes visible within one cycle of the stall and is caught by the bench's in-order queue. The bench therefore mixes directed corner cases with a long random stream under random back-pressure.

// File: rtl/bcls_pkg.sv
package bcls_pkg;
  localparam int CLS_W = 18;
  typedef logic [CLS_W-1:0] cls_t;

  localparam int B_USER    = 0;
  localparam int B_KERNEL  = 1;
  localparam int B_CALL    = 2;
  localparam int B_RET     = 3;
  localparam int B_SYSCALL = 4;
  localparam int B_SYSRET  = 5;
  localparam int B_SWINT   = 6;
  localparam int B_IRET    = 7;
  localparam int B_COND    = 8;
  localparam int B_JUMP    = 9;
  localparam int B_IRQ     = 10;
  localparam int B_INDCALL = 11;
  localparam int B_ABORT   = 12;
  localparam int B_ZCALL   = 15;
  localparam int B_INDJMP  = 17;

  function automatic cls_t bit_of(input int pos);
    cls_t r;
    r = '0;
    r[pos] = 1'b1;
    return r;
  endfunction

  // Opcode table lookup: at most one class bit, no privilege bits.
  function automatic cls_t decode_op(input logic [7:0] op0, input logic [7:0] op1,
                                     input logic [7:0] modrm, input logic imm_zero);
    cls_t r;
    r = '0;
    if (op0 == 8'h0F) begin
      if (op1 == 8'h05 || op1 == 8'h34)      r = bit_of(B_SYSCALL);
      else if (op1 == 8'h07 || op1 == 8'h35) r = bit_of(B_SYSRET);
      else if (op1[7:4] == 4'h8)             r = bit_of(B_COND);
    end else if (op0[7:4] == 4'h7)            r = bit_of(B_COND);
    else begin
      case (op0)
        8'hE0, 8'hE1, 8'hE2, 8'hE3: r = bit_of(B_COND);
        8'hC2, 8'hC3, 8'hCA, 8'hCB: r = bit_of(B_RET);
        8'hCF:                      r = bit_of(B_IRET);
        8'hCC, 8'hCD, 8'hCE:        r = bit_of(B_SWINT);
        8'hE8:                      r = imm_zero ? bit_of(B_ZCALL) : bit_of(B_CALL);
        8'h9A:                      r = bit_of(B_CALL);
        8'hE9, 8'hEA, 8'hEB:        r = bit_of(B_JUMP);
        8'hFF: begin
          case (modrm[5:3])
            3'd2, 3'd3: r = bit_of(B_INDCALL);
            3'd4, 3'd5: r = bit_of(B_INDJMP);
            default:    r = '0;
          endcase
        end
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  // Priority: zero address, abort, missing bytes, transition inference.
  function automatic cls_t merge_priv(input cls_t raw, input logic from_zero,
                                      input logic to_zero, input logic abort,
                                      input logic bytes_ok, input logic src_k,
                                      input logic dst_k);
    cls_t plm;
    cls_t r;
    plm = dst_k ? bit_of(B_KERNEL) : bit_of(B_USER);
    if (from_zero || to_zero)   r = '0;
    else if (abort)             r = bit_of(B_ABORT) | plm;
    else if (!bytes_ok)         r = '0;
    else begin
      r = raw;
      if (!src_k && dst_k && !raw[B_SYSCALL] && !raw[B_SWINT]) r = bit_of(B_IRQ);
      if (r != '0) r = r | plm;
    end
    return r;
  endfunction
endpackage

// File: rtl/bcls_opcode_dec.sv
module bcls_opcode_dec
  import bcls_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [7:0]       op0,
  input  logic [7:0]       op1,
  input  logic [7:0]       modrm,
  input  logic [IMM_W-1:0] imm,
  output cls_t             raw_class
);
  logic imm_zero;
  assign imm_zero  = (imm == '0);
  assign raw_class = decode_op(op0, op1, modrm, imm_zero);

  always_comb begin
    // r10: the table never emits privilege bits and never two classes
    a_r10_raw_single: assert ($countones(raw_class) <= 1 && raw_class[1:0] == 2'b00);
  end
endmodule

// File: rtl/bcls_priv_merge.sv
module bcls_priv_merge
  import bcls_pkg::*;
(
  input  cls_t raw_class,
  input  logic from_zero,
  input  logic to_zero,
  input  logic abort,
  input  logic bytes_ok,
  input  logic src_kernel,
  input  logic dst_kernel,
  output cls_t final_class
);
  assign final_class = merge_priv(raw_class, from_zero, to_zero, abort,
                                  bytes_ok, src_kernel, dst_kernel);

  always_comb begin
    // r2: a zero address wins over every other input
    a_r2_zero_addr: assert (!(from_zero || to_zero) || final_class == '0);
  end
endmodule

// File: rtl/bcls_pipe_stage.sv
module bcls_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         take;

  assign up_ready = !vld_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        vld_q <= 1'b0;
    else if (up_ready) vld_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (take) dat_q <= up_data;
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !dn_ready) |=> (vld_q && $stable(dat_q)));
endmodule

// File: rtl/branch_classifier.sv
module branch_classifier
  import bcls_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode0,
  input  logic [7:0]       in_opcode1,
  input  logic [7:0]       in_modrm,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             in_bytes_ok,
  input  logic             in_from_zero,
  input  logic             in_to_zero,
  input  logic             in_src_kernel,
  input  logic             in_dst_kernel,
  input  logic             in_abort,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [17:0]      out_class
);
  localparam int FLAG_W = 6;
  localparam int S1_W   = CLS_W + FLAG_W;

  cls_t            raw_class;
  logic [S1_W-1:0] s1_in, s1_out;
  logic            s1_valid, s1_ready;
  cls_t            merged_class;
  cls_t            s1_raw;
  logic            s1_fz, s1_tz, s1_ab, s1_ok, s1_sk, s1_dk;

  bcls_opcode_dec #(.IMM_W(IMM_W)) u_dec (
    .op0(in_opcode0), .op1(in_opcode1), .modrm(in_modrm), .imm(in_imm),
    .raw_class(raw_class)
  );

  assign s1_in = {raw_class, in_from_zero, in_to_zero, in_abort,
                  in_bytes_ok, in_src_kernel, in_dst_kernel};

  bcls_pipe_stage #(.W(S1_W)) u_st1 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(s1_in),
    .dn_valid(s1_valid), .dn_ready(s1_ready), .dn_data(s1_out)
  );

  assign {s1_raw, s1_fz, s1_tz, s1_ab, s1_ok, s1_sk, s1_dk} = s1_out;

  bcls_priv_merge u_merge (
    .raw_class(s1_raw), .from_zero(s1_fz), .to_zero(s1_tz), .abort(s1_ab),
    .bytes_ok(s1_ok), .src_kernel(s1_sk), .dst_kernel(s1_dk),
    .final_class(merged_class)
  );

  bcls_pipe_stage #(.W(CLS_W)) u_st2 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s1_valid), .up_ready(s1_ready), .up_data(merged_class),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_class)
  );

  // R10: non-empty result carries exactly one target-privilege bit
  a_r10_one_plm: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class != '0) |-> $onehot(out_class[1:0]));
  // R10: at most one class bit above the privilege pair
  a_r10_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_class[17:2]) <= 1));
  // R9: an inferred irq/trap/fault always lands in the kernel
  a_r9_irq_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class[B_IRQ]) |-> out_class[B_KERNEL]);
  // R3: abort results carry only the abort bit and one privilege bit
  a_r3_abort_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class[B_ABORT]) |-> ($countones(out_class) == 2));
  // R11: a stalled output does not move
  a_r11_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_class)));
endmodule

// File: tb/tb_branch_classifier.sv
module tb_branch_classifier;
  localparam int IMM_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_opcode0 = '0, in_opcode1 = '0, in_modrm = '0;
  logic [IMM_W-1:0] in_imm = '0;
  logic             in_bytes_ok = 1'b1, in_from_zero = 1'b0, in_to_zero = 1'b0;
  logic             in_src_kernel = 1'b0, in_dst_kernel = 1'b0, in_abort = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [17:0]      out_class;

  branch_classifier #(.IMM_W(IMM_W)) dut (.*);

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];
  bit          stall_seen = 1'b0;
  logic [17:0] stall_val;
  int          lat_cnt = 0;
  int          lat_first = -1;

  function automatic logic [17:0] ref_class(logic [7:0] a, logic [7:0] b, logic [7:0] m,
      logic [IMM_W-1:0] imm, logic ok, logic fz, logic tz, logic sk, logic dk, logic ab);
    int k;
    int reg_f;
    logic [17:0] plm;
    plm = dk ? 18'd2 : 18'd1;
    if (fz || tz) return 18'd0;
    if (ab) return (18'd1 << 12) | plm;
    if (!ok) return 18'd0;
    k = -1;
    reg_f = (m / 8) % 8;
    if (a == 15) begin
      if (b == 5 || b == 52) k = 4;
      if (b == 7 || b == 53) k = 5;
      if (b >= 128 && b <= 143) k = 8;
    end
    else if (a >= 112 && a <= 127) k = 8;
    else if (a >= 224 && a <= 227) k = 8;
    else if (a == 194 || a == 195 || a == 202 || a == 203) k = 3;
    else if (a == 207) k = 7;
    else if (a >= 204 && a <= 206) k = 6;
    else if (a == 232) k = (imm == 0) ? 15 : 2;
    else if (a == 154) k = 2;
    else if (a >= 233 && a <= 235) k = 9;
    else if (a == 255) begin
      if (reg_f == 2 || reg_f == 3) k = 11;
      if (reg_f == 4 || reg_f == 5) k = 17;
    end
    if (!sk && dk && k != 4 && k != 6) k = 10;
    if (k < 0) return 18'd0;
    return (18'd1 << k) | plm;
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One negedge step: drive, then record what the next posedge transfers.
  task automatic step(bit v, string tag, logic [7:0] a, logic [7:0] b, logic [7:0] m,
      logic [IMM_W-1:0] imm, logic ok, logic fz, logic tz, logic sk, logic dk,
      logic ab, bit ordy);
    @(negedge clk);
    if (stall_seen) begin
      check("R11 stall hold", {17'd0, out_valid}, 18'd1);
      check("R11 stall hold", out_class, stall_val);
    end
    in_valid = v; in_opcode0 = a; in_opcode1 = b; in_modrm = m; in_imm = imm;
    in_bytes_ok = ok; in_from_zero = fz; in_to_zero = tz;
    in_src_kernel = sk; in_dst_kernel = dk; in_abort = ab; out_ready = ordy;
    #1;
    stall_seen = out_valid && !out_ready;
    stall_val  = out_class;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R11 spurious output", 18'h3FFFF, 18'd0);
      else check(tag_q.pop_front(), out_class, exp_q.pop_front());
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_class(a, b, m, imm, ok, fz, tz, sk, dk, ab));
      tag_q.push_back(tag);
    end
  endtask

  task automatic op(string tag, logic [7:0] a, logic [7:0] b, logic [7:0] m,
      logic [IMM_W-1:0] imm, logic sk, logic dk);
    step(1'b1, tag, a, b, m, imm, 1'b1, 1'b0, 1'b0, sk, dk, 1'b0, 1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++)
      step(1'b0, "idle", 8'h00, 8'h00, 8'h00, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset out_valid", {17'd0, out_valid}, 18'd0);
    check("R1 reset in_ready", {17'd0, in_ready}, 18'd1);

    // R11 latency: accept at one edge, result valid after the second
    @(negedge clk);
    in_valid = 1'b1; in_opcode0 = 8'hC3; in_dst_kernel = 1'b0; in_src_kernel = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 latency not yet", {17'd0, out_valid}, 18'd0);
    @(negedge clk);
    check("R11 latency two", {17'd0, out_valid}, 18'd1);
    check("R11 latency value", out_class, 18'h00009);
    @(negedge clk);
    check("R11 drained", {17'd0, out_valid}, 18'd0);

    // R5 single-byte map
    op("R5 jcc 0x70", 8'h70, 0, 0, 1, 0, 0);
    op("R5 jcc 0x7F", 8'h7F, 0, 0, 1, 0, 0);
    op("R5 loop 0xE3", 8'hE3, 0, 0, 1, 1, 1);
    op("R5 ret 0xC2", 8'hC2, 0, 0, 1, 0, 0);
    op("R5 ret 0xCB", 8'hCB, 0, 0, 1, 1, 1);
    op("R5 iret", 8'hCF, 0, 0, 1, 1, 0);
    op("R5 int 0xCD", 8'hCD, 0, 0, 1, 0, 0);
    op("R5 far call", 8'h9A, 0, 0, 1, 0, 0);
    op("R5 jmp 0xEB", 8'hEB, 0, 0, 1, 1, 1);
    // R6 escape map
    op("R6 syscall 05", 8'h0F, 8'h05, 0, 1, 0, 0);
    op("R6 sysenter 34", 8'h0F, 8'h34, 0, 1, 1, 1);
    op("R6 sysret 07", 8'h0F, 8'h07, 0, 1, 1, 0);
    op("R6 sysexit 35", 8'h0F, 8'h35, 0, 1, 1, 0);
    op("R6 jcc 8F", 8'h0F, 8'h8F, 0, 1, 0, 0);
    op("R12 escape other", 8'h0F, 8'h90, 0, 1, 0, 0);
    // R7 relative call
    op("R7 call nonzero", 8'hE8, 0, 0, 32'h10, 0, 0);
    op("R7 zero call", 8'hE8, 0, 0, 0, 0, 0);
    // R8 ModRM extension
    op("R8 reg2", 8'hFF, 0, 8'h10, 1, 0, 0);
    op("R8 reg3", 8'hFF, 0, 8'hD8, 1, 1, 1);
    op("R8 reg4", 8'hFF, 0, 8'h20, 1, 0, 0);
    op("R8 reg5", 8'hFF, 0, 8'h2C, 1, 0, 0);
    op("R8 reg0", 8'hFF, 0, 8'h00, 1, 0, 0);
    // R9 transition inference
    op("R9 jcc user->kernel", 8'h74, 0, 0, 1, 0, 1);
    op("R9 unknown user->kernel", 8'h90, 0, 0, 1, 0, 1);
    op("R9 syscall kept", 8'h0F, 8'h05, 0, 1, 0, 1);
    op("R9 int kept", 8'hCC, 0, 0, 1, 0, 1);
    op("R10 kernel->user ret", 8'hC3, 0, 0, 1, 1, 0);
    op("R12 unknown opcode", 8'h90, 0, 0, 1, 1, 1);
    // R2, R3, R4 priority
    step(1'b1, "R2 from zero", 8'hC3, 0, 0, 1, 1, 1, 0, 0, 1, 1, 1'b1);
    step(1'b1, "R2 to zero", 8'hE8, 0, 0, 1, 1, 0, 1, 1, 1, 0, 1'b1);
    step(1'b1, "R3 abort kernel", 8'h90, 0, 0, 1, 0, 0, 0, 0, 1, 1, 1'b1);
    step(1'b1, "R3 abort user", 8'hC3, 0, 0, 1, 1, 0, 0, 1, 0, 1, 1'b1);
    step(1'b1, "R4 bytes bad", 8'hC3, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1'b1);
    drain();

    // R11 random stream under random back-pressure
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 7);
      case (pick)
        0: a = 8'h0F;
        1: a = 8'hFF;
        2: a = 8'hE8;
        3: a = 8'h70 + 8'($urandom_range(0, 15));
        4: a = 8'hC0 + 8'($urandom_range(0, 15));
        5: a = 8'hE0 + 8'($urandom_range(0, 15));
        default: a = 8'($urandom);
      endcase
      step($urandom_range(0, 3) != 0, "R11 stream", a,
           ($urandom_range(0, 1) != 0) ? 8'h80 + 8'($urandom_range(0, 31)) : 8'($urandom),
           8'($urandom), ($urandom_range(0, 3) == 0) ? 32'd0 : 32'($urandom),
           $urandom_range(0, 15) != 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0, 1'($urandom), 1'($urandom),
           $urandom_range(0, 15) == 0, $urandom_range(0, 2) != 0);
    end
    drain();
    check("R11 queue empty", 18'(exp_q.size()), 18'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule